// File: doc/BRIEF.md
# Masked Two-Table Vector Permute Unit

This block builds a result vector whose elements are each taken from a lookup table formed by two whole source vectors. The per-element index comes from one of the operands. The table is twice as wide as the vector, so an index may point at any element of either half. The unit supports 32-bit and 64-bit elements and vector lengths of 128, 256 and 512 bits. The result is registered and appears one clock after it is requested.

There are two operating variants, and each comes in an integer form and a floating-point form. Both forms move raw bits, so they behave the same. In the index-overwrite variant, the old destination supplies the indices, and the table halves are the first and second sources. In the table-overwrite variant, the first source supplies the indices, and the table halves are the old destination and the second source. Every table read uses the operand values presented with the request.

An optional per-element write mask decides which elements take the permuted value. A masked-off element either keeps its old destination value or is cleared, depending on a zeroing control. Bits above the active vector length are always cleared.

Top module: `vperm_unit`

## Requirements
- R1: The active length is 128, 256 or 512 bits for `vlen_sel` 0, 1 or 2, and code 3 also means 512 bits. Every output bit at or above the active length is zero, whatever the mask settings.
- R2: The element count is the active length divided by the element width. The index of element n is the low log2(count) bits of index element n. Index bits above the half-select bit have no effect.
- R3: The index-element bit whose weight equals the element count picks the table half. When set, the element is read from `src_b`. When clear, it is read from the other half.
- R4: When `op_sel[1]`=0 (index-overwrite), the indices come from `dst_old`, the half with the select bit clear is `src_a`, and the half with it set is `src_b`.
- R5: When `op_sel[1]`=1 (table-overwrite), the indices come from `src_a`, the half with the select bit clear is `dst_old`, and the half with it set is `src_b`.
- R6: `op_sel[0]` (integer form 0, floating-point form 1) has no effect on the result.
- R7: When `mask_en`=0, every active element takes its permuted value.
- R8: When `mask_en`=1 and `zero_mask`=0, element n takes its permuted value if `wmask[n]`=1 and otherwise keeps `dst_old` element n. All 16 mask bits are used for 32-bit elements. Only `wmask[7:0]` is used for 64-bit elements.
- R9: When `mask_en`=1 and `zero_mask`=1, a masked-off active element is zero.
- R10: A request sampled with `in_valid`=1 at a rising edge appears on `out_vec` with `out_valid`=1 right after that edge. While `in_valid`=0, `out_valid` is 0 and `out_vec` keeps its value.
- R11: While reset is active, and until the first request, `out_valid` is 0 and `out_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Bit 1: variant (0 index-overwrite, 1 table-overwrite); bit 0: integer/floating-point form |
| wide_elem | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| vlen_sel | input | 2 | Active vector length code |
| mask_en | input | 1 | Enables the write mask |
| zero_mask | input | 1 | Masked-off elements: 0 keep old value, 1 clear |
| wmask | input | 16 | Per-element write mask |
| dst_old | input | 512 | Old destination register value |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| out_valid | output | 1 | Result strobe |
| out_vec | output | 512 | New destination register value |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid` high. Any following cycle with `in_valid` low must leave the result unchanged. The bench therefore changes inputs on falling edges only. It compares the output on the next falling edge after each request, and it checks the hold behaviour one cycle later after changing the inputs. Expected vectors come from an element-by-element reference loop in the bench. Several directed cases instead use values written out by hand: the half-select bit, the length code 3, and the upper mask bits for 64-bit elements.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

  typedef enum logic [1:0] {
    VLEN_128 = 2'd0,
    VLEN_256 = 2'd1,
    VLEN_512 = 2'd2,
    VLEN_ALT = 2'd3
  } vlen_code_e;

  typedef enum logic [1:0] {
    OP_IDXOVW_INT = 2'd0,
    OP_IDXOVW_FP  = 2'd1,
    OP_TBLOVW_INT = 2'd2,
    OP_TBLOVW_FP  = 2'd3
  } perm_op_e;

  // Collapse the spare length code onto the widest length.
  function automatic logic [1:0] vlen_shift(input logic [1:0] code);
    return (code == VLEN_ALT) ? 2'd2 : code;
  endfunction

  function automatic logic is_table_ovw(input logic [1:0] op);
    return op[1];
  endfunction

endpackage

// File: rtl/vperm_ctrl.sv
module vperm_ctrl #(
  parameter int NLANES     = 16,
  parameter int BASE_LANES = 4,
  parameter int CNT_W      = $clog2(NLANES) + 1
) (
  input  logic              wide_elem,
  input  logic [1:0]        vlen_sel,
  input  logic              mask_en,
  input  logic [NLANES-1:0] wmask,
  output logic [CNT_W-1:0]  cnt_n,
  output logic [NLANES-1:0] lane_act,
  output logic [NLANES-1:0] lane_wr
);
  import vperm_pkg::*;

  logic [1:0] shamt;

  always_comb begin
    shamt = vlen_shift(vlen_sel);
    cnt_n = CNT_W'(BASE_LANES) << shamt;
  end

  for (genvar g = 0; g < NLANES; g++) begin : g_lane_ctl
    localparam int PAIR = g / 2;
    assign lane_act[g] = (CNT_W'(g) < cnt_n);
    assign lane_wr[g]  = !mask_en || (wide_elem ? wmask[PAIR] : wmask[g]);
  end

endmodule

// File: rtl/vperm_lane.sv
module vperm_lane #(
  parameter int LANE_W = 32,
  parameter int NLANES = 16,
  parameter int LANE   = 0,
  parameter int LIDX_W = $clog2(NLANES),
  parameter int CNT_W  = LIDX_W + 1,
  parameter int VEC_W  = NLANES * LANE_W
) (
  input  logic              wide_elem,
  input  logic [CNT_W-1:0]  cnt_n,
  input  logic [CNT_W-1:0]  idx_narrow,
  input  logic [CNT_W-1:0]  idx_wide,
  input  logic [VEC_W-1:0]  tbl_lo,
  input  logic [VEC_W-1:0]  tbl_hi,
  output logic [LANE_W-1:0] lane_val
);
  localparam logic LANE_ODD = 1'(LANE % 2);

  logic [CNT_W-1:0]  raw;
  logic [CNT_W-1:0]  ecnt;
  logic [LIDX_W-1:0] emask;
  logic [LIDX_W-1:0] jdx;
  logic              hi_half;
  logic [LIDX_W-1:0] src_lane;
  logic [VEC_W-1:0]  tbl;

  always_comb begin
    raw      = wide_elem ? idx_wide : idx_narrow;
    ecnt     = wide_elem ? (cnt_n >> 1) : cnt_n;
    emask    = LIDX_W'(ecnt - CNT_W'(1));
    jdx      = raw[LIDX_W-1:0] & emask;
    hi_half  = |(raw & ecnt);
    src_lane = wide_elem ? {jdx[LIDX_W-2:0], LANE_ODD} : jdx;
    tbl      = hi_half ? tbl_hi : tbl_lo;
    lane_val = tbl[src_lane*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/vperm_merge.sv
module vperm_merge #(
  parameter int LANE_W = 32,
  parameter int NLANES = 16,
  parameter int VEC_W  = NLANES * LANE_W
) (
  input  logic [VEC_W-1:0]  perm_vec,
  input  logic [VEC_W-1:0]  old_vec,
  input  logic [NLANES-1:0] lane_act,
  input  logic [NLANES-1:0] lane_wr,
  input  logic              zero_mask,
  output logic [VEC_W-1:0]  res_vec
);

  for (genvar g = 0; g < NLANES; g++) begin : g_merge
    always_comb begin
      if (!lane_act[g]) begin
        res_vec[g*LANE_W +: LANE_W] = '0;
      end else if (lane_wr[g]) begin
        res_vec[g*LANE_W +: LANE_W] = perm_vec[g*LANE_W +: LANE_W];
      end else if (zero_mask) begin
        res_vec[g*LANE_W +: LANE_W] = '0;
      end else begin
        res_vec[g*LANE_W +: LANE_W] = old_vec[g*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit #(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 32,
  parameter int BASE_W = 128,
  parameter int NLANES = VEC_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic              wide_elem,
  input  logic [1:0]        vlen_sel,
  input  logic              mask_en,
  input  logic              zero_mask,
  input  logic [NLANES-1:0] wmask,
  input  logic [VEC_W-1:0]  dst_old,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_vec
);
  import vperm_pkg::*;

  localparam int LIDX_W     = $clog2(NLANES);
  localparam int CNT_W      = LIDX_W + 1;
  localparam int BASE_LANES = BASE_W / LANE_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // Operand routing per variant.
  logic             tbl_ovw;
  logic [VEC_W-1:0] tbl_lo;
  logic [CNT_W-1:0] idx_n [NLANES];

  assign tbl_ovw = is_table_ovw(op_sel);
  assign tbl_lo  = tbl_ovw ? dst_old : src_a;

  for (genvar g = 0; g < NLANES; g++) begin : g_idx
    assign idx_n[g] = tbl_ovw ? src_a[g*LANE_W +: CNT_W] : dst_old[g*LANE_W +: CNT_W];
  end

  logic [CNT_W-1:0]  cnt_n;
  logic [NLANES-1:0] lane_act;
  logic [NLANES-1:0] lane_wr;

  vperm_ctrl #(
    .NLANES    (NLANES),
    .BASE_LANES(BASE_LANES),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .wide_elem(wide_elem),
    .vlen_sel (vlen_sel),
    .mask_en  (mask_en),
    .wmask    (wmask),
    .cnt_n    (cnt_n),
    .lane_act (lane_act),
    .lane_wr  (lane_wr)
  );

  logic [VEC_W-1:0] perm_vec;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int PAIR_BASE = (g / 2) * 2;
    vperm_lane #(
      .LANE_W(LANE_W),
      .NLANES(NLANES),
      .LANE  (g),
      .LIDX_W(LIDX_W),
      .CNT_W (CNT_W),
      .VEC_W (VEC_W)
    ) u_lane (
      .wide_elem (wide_elem),
      .cnt_n     (cnt_n),
      .idx_narrow(idx_n[g]),
      .idx_wide  (idx_n[PAIR_BASE]),
      .tbl_lo    (tbl_lo),
      .tbl_hi    (src_b),
      .lane_val  (perm_vec[g*LANE_W +: LANE_W])
    );
  end

  logic [VEC_W-1:0] res_vec;

  vperm_merge #(
    .LANE_W(LANE_W),
    .NLANES(NLANES),
    .VEC_W (VEC_W)
  ) u_merge (
    .perm_vec (perm_vec),
    .old_vec  (dst_old),
    .lane_act (lane_act),
    .lane_wr  (lane_wr),
    .zero_mask(zero_mask),
    .res_vec  (res_vec)
  );

  // Output stage: next-state logic, then registers.
  logic             valid_nxt;
  logic [VEC_W-1:0] vec_nxt;

  always_comb begin
    valid_nxt = in_valid;
    vec_nxt   = in_valid ? res_vec : out_vec;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= valid_nxt;
      out_vec   <= vec_nxt;
    end
  end

  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> (!out_valid && $stable(out_vec)));

  // R1
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && vlen_sel == 2'd0) |=> (out_vec[VEC_W-1:BASE_W] == '0));

  // R8
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && mask_en && !zero_mask && !wide_elem && !wmask[0])
      |=> (out_vec[LANE_W-1:0] == $past(dst_old[LANE_W-1:0])));

  // R9
  zero_all_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && mask_en && zero_mask && wmask == '0) |=> (out_vec == '0));

  // R11
  always_ff @(posedge clk) begin
    if (!rst_q) begin
      reset_state_chk: assert (!out_valid && out_vec == '0);
    end
  end

endmodule

// File: tb/vperm_unit_test.sv
module vperm_unit_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   op_sel;
  logic         wide_elem;
  logic [1:0]   vlen_sel;
  logic         mask_en;
  logic         zero_mask;
  logic [15:0]  wmask;
  logic [511:0] dst_old;
  logic [511:0] src_a;
  logic [511:0] src_b;
  logic         out_valid;
  logic [511:0] out_vec;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vperm_unit uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_sel   (op_sel),
    .wide_elem(wide_elem),
    .vlen_sel (vlen_sel),
    .mask_en  (mask_en),
    .zero_mask(zero_mask),
    .wmask    (wmask),
    .dst_old  (dst_old),
    .src_a    (src_a),
    .src_b    (src_b),
    .out_valid(out_valid),
    .out_vec  (out_vec)
  );

  function automatic logic [511:0] rvec();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // Element-by-element reference built from the requirements.
  function automatic logic [511:0] ref_perm(
    input logic [1:0] op, input logic w, input logic [1:0] vl,
    input logic men, input logic zm, input logic [15:0] wm,
    input logic [511:0] d, input logic [511:0] a, input logic [511:0] b);
    logic [511:0] r, ix, t0;
    int bits, cnt;
    r    = '0;
    bits = (vl == 2'd3) ? 512 : (128 << vl);
    ix   = op[1] ? a : d;
    t0   = op[1] ? d : a;
    if (w) begin
      cnt = bits / 64;
      for (int n = 0; n < cnt; n++) begin
        logic [63:0] ie, v;
        int j;
        ie = ix[n*64 +: 64];
        j  = int'(ie & 64'(cnt - 1));
        v  = ((ie & 64'(cnt)) != 0) ? b[j*64 +: 64] : t0[j*64 +: 64];
        if (!men || wm[n]) r[n*64 +: 64] = v;
        else               r[n*64 +: 64] = zm ? 64'd0 : d[n*64 +: 64];
      end
    end else begin
      cnt = bits / 32;
      for (int n = 0; n < cnt; n++) begin
        logic [31:0] ie, v;
        int j;
        ie = ix[n*32 +: 32];
        j  = int'(ie & 32'(cnt - 1));
        v  = ((ie & 32'(cnt)) != 0) ? b[j*32 +: 32] : t0[j*32 +: 32];
        if (!men || wm[n]) r[n*32 +: 32] = v;
        else               r[n*32 +: 32] = zm ? 32'd0 : d[n*32 +: 32];
      end
    end
    return r;
  endfunction

  task automatic chk_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive on a falling edge; result is sampled one falling edge later.
  task automatic issue(input logic [1:0] op, input logic w, input logic [1:0] vl,
                       input logic men, input logic zm, input logic [15:0] wm,
                       input logic [511:0] d, input logic [511:0] a, input logic [511:0] b);
    @(negedge clk);
    op_sel = op; wide_elem = w; vlen_sel = vl; mask_en = men; zero_mask = zm;
    wmask = wm; dst_old = d; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_ref(input string tag, input logic [1:0] op, input logic w,
                         input logic [1:0] vl, input logic men, input logic zm,
                         input logic [15:0] wm, input logic [511:0] d,
                         input logic [511:0] a, input logic [511:0] b);
    issue(op, w, vl, men, zm, wm, d, a, b);
    chk_vec(tag, out_vec, ref_perm(op, w, vl, men, zm, wm, d, a, b));
    chk_bit({tag, " R10 valid"}, out_valid, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] d, a, b, keep, cap;
    in_valid = 1'b0; op_sel = '0; wide_elem = 1'b0; vlen_sel = '0;
    mask_en = 1'b0; zero_mask = 1'b0; wmask = '0;
    dst_old = '0; src_a = '0; src_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk_bit("R11 valid in reset", out_valid, 1'b0);
    chk_vec("R11 data in reset", out_vec, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_bit("R11 valid after release", out_valid, 1'b0);
    chk_vec("R11 data after release", out_vec, '0);

    // Sweep over variants, sizes, lengths and mask modes.
    for (int op = 0; op < 4; op++)
      for (int w = 0; w < 2; w++)
        for (int vl = 0; vl < 3; vl++)
          for (int mm = 0; mm < 3; mm++)
            for (int rep = 0; rep < 4; rep++) begin
              string tag;
              tag = (op >= 2) ? "R5" : "R4";
              tag = {tag, (mm == 0) ? " R7" : (mm == 1) ? " R8" : " R9", " R2 R3 R1"};
              run_ref(tag, 2'(op), 1'(w), 2'(vl), mm != 0, mm == 2, 16'($urandom),
                      rvec(), rvec(), rvec());
            end

    // R3: selector bit set with index 0 -> every element is src_b element 0
    a = '0; b = rvec(); d = rvec();
    for (int i = 0; i < 16; i++) a[i*32 +: 32] = 32'd16;
    issue(2'd2, 1'b0, 2'd2, 1'b0, 1'b0, '0, d, a, b);
    chk_vec("R3 all from second source", out_vec, {16{b[31:0]}});

    // R2: high index bits above the selector are ignored (count 4, select weight 4)
    d = '0; a = rvec(); b = rvec();
    for (int i = 0; i < 4; i++) d[i*32 +: 32] = 32'hFFFF_FF08 | 32'(3 - i);
    issue(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, '0, d, a, b);
    chk_vec("R2 upper index bits ignored", out_vec,
            {384'd0, a[31:0], a[63:32], a[95:64], a[127:96]});

    // R1: length code 3 acts as 512 bits
    d = rvec(); a = rvec(); b = rvec();
    issue(2'd2, 1'b1, 2'd3, 1'b0, 1'b0, '0, d, a, b);
    chk_vec("R1 code 3 is 512 bits", out_vec, ref_perm(2'd2, 1'b1, 2'd2, 1'b0, 1'b0, '0, d, a, b));

    // R1: short length with merge mode still clears upper bits
    issue(2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0000, d, a, b);
    chk_vec("R1 upper cleared in merge", out_vec, {384'd0, d[127:0]});

    // R8: 64-bit elements ignore upper mask byte
    issue(2'd0, 1'b1, 2'd2, 1'b1, 1'b0, 16'hFF00, d, a, b);
    chk_vec("R8 upper mask bits unused", out_vec, d);

    // R9: zeroing with empty mask clears all
    issue(2'd3, 1'b0, 2'd2, 1'b1, 1'b1, 16'h0000, d, a, b);
    chk_vec("R9 zero all", out_vec, '0);

    // R6: integer and floating-point forms match
    issue(2'd2, 1'b0, 2'd1, 1'b1, 1'b0, 16'h5A, d, a, b);
    cap = out_vec;
    issue(2'd3, 1'b0, 2'd1, 1'b1, 1'b0, 16'h5A, d, a, b);
    chk_vec("R6 fp form equals int form", out_vec, cap);

    // R10: output holds while idle even as inputs change
    keep = out_vec;
    @(negedge clk);
    dst_old = rvec(); src_a = rvec(); src_b = rvec(); op_sel = 2'd0;
    @(negedge clk);
    chk_vec("R10 hold while idle", out_vec, keep);
    chk_bit("R10 valid low while idle", out_valid, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule